// File: doc/BRIEF.md
# Serial DAC Frame Driver

This block sits on the host side of a dual 12-bit serial digital-to-analog converter. It accepts one write request at a time over a valid/ready handshake. Each request carries a 2-bit channel address and a 12-bit code. The block then produces the four wires the converter expects: a serial clock, a serial data line, an active-low select and an active-low load strobe.

A frame starts by pulling select low and waiting. The 14 bits then go out address-first, each presented while the clock is low and taken by the converter on the clock's rising edge. Select is released after a trailing wait. A separate load pulse follows, which moves the shifted word into the addressed channel register or registers. Every interval is a count of system clock cycles, fixed by a parameter, so a fast core clock can meet the converter's nanosecond minimums.

When the load pulse has finished, the block waits a hold interval, returns to idle and raises a one-cycle completion pulse.

Top module: `sdac_frame_drv`

## Requirements
- R1: Out of reset and whenever idle, `dac_sck` is low, `dac_cs_n` is high, `dac_ld_n` is high, `req_ready` is high and `done` is low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the frame has completed. Inputs presented while busy do not alter the frame in flight.
- R3: The 14 frame bits appear on `dac_sdo` in this order: `req_chan[1]`, `req_chan[0]`, then `req_code[11]` down to `req_code[0]`. Each bit is the value on the line at a rising edge of `dac_sck`.
- R4: `dac_cs_n` is low for exactly T_CSS cycles before the first rising edge of `dac_sck`.
- R5: Each frame has exactly 14 high phases of `dac_sck`, each lasting T_HI cycles, separated by low phases of T_LO cycles. `dac_sck` is high only while `dac_cs_n` is low.
- R6: After the last high phase, `dac_cs_n` stays low for exactly T_CSH cycles with `dac_sck` low, and then rises.
- R7: `dac_ld_n` is low only while `dac_cs_n` is high and `dac_sck` is low. It falls T_LD1 cycles after `dac_cs_n` rises and stays low for exactly T_LDW cycles.
- R8: After `dac_ld_n` rises, the block waits T_LD2 cycles and then pulses `done` for one cycle. `req_ready` is high in that same cycle.
- R9: `dac_sdo` changes only while `dac_sck` is low, so it is steady for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | ADDR_W | Channel address, sent first, MSB first |
| req_code | input | CODE_W | Converter code, sent MSB first after the address |
| done | output | 1 | One-cycle pulse when a frame has fully completed |
| dac_sck | output | 1 | Serial clock to the converter |
| dac_sdo | output | 1 | Serial data to the converter |
| dac_cs_n | output | 1 | Active-low select |
| dac_ld_n | output | 1 | Active-low load strobe |

## Verification
The assertions assume that every timing parameter is at least one cycle. They also assume `req_valid` is low while reset is held. They do not assume the request fields stay stable after acceptance.

The stimulus keeps `req_valid` low during reset. It deliberately holds `req_valid` high with changed data through a busy frame, to show that the block ignores it. Serial timing is checked by a pin monitor that measures the run length of each wire state. The bench does not rely on a fixed cycle count from the request to any edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP,
    ST_LOAD,
    ST_HOLD
  } seq_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_interval_timer.sv
module sdac_interval_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)
      cnt_d = len - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sdac_word_shifter.sv
module sdac_word_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         sdo,
  output logic         last
);

  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [LW-1:0] left_q, left_d;
  logic          en;

  always_comb begin
    en     = load || shift;
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = word;
      left_d = LW'(W);
    end else if (shift) begin
      sh_d   = {sh_q[W-2:0], 1'b0};
      left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign sdo  = sh_q[W-1];
  assign last = (left_q == LW'(1));

endmodule

// File: rtl/sdac_seq_fsm.sv
module sdac_seq_fsm
  import sdac_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_CSS = 3,
  parameter int T_HI  = 3,
  parameter int T_LO  = 4,
  parameter int T_CSH = 2,
  parameter int T_LD1 = 2,
  parameter int T_LDW = 3,
  parameter int T_LD2 = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             expire,
  input  logic             last,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             shift,
  output logic             frame_end
);

  always_comb begin
    state_d = state_q;
    shift   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_fire) state_d = ST_LEAD;
      ST_LEAD: if (expire)   state_d = ST_HIGH;
      ST_HIGH: begin
        if (expire) begin
          if (last) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_LOW;
            shift   = 1'b1;
          end
        end
      end
      ST_LOW:  if (expire) state_d = ST_HIGH;
      ST_TAIL: if (expire) state_d = ST_GAP;
      ST_GAP:  if (expire) state_d = ST_LOAD;
      ST_LOAD: if (expire) state_d = ST_HOLD;
      ST_HOLD: if (expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_LEAD: tmr_len = CNT_W'(T_CSS);
      ST_HIGH: tmr_len = CNT_W'(T_HI);
      ST_LOW:  tmr_len = CNT_W'(T_LO);
      ST_TAIL: tmr_len = CNT_W'(T_CSH);
      ST_GAP:  tmr_len = CNT_W'(T_LD1);
      ST_LOAD: tmr_len = CNT_W'(T_LDW);
      ST_HOLD: tmr_len = CNT_W'(T_LD2);
      default: tmr_len = CNT_W'(1);
    endcase
  end

  assign tmr_load  = (state_d != state_q);
  assign frame_end = (state_q == ST_HOLD) && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else if (tmr_load)
      state_q <= state_d;
  end

endmodule

// File: rtl/sdac_frame_drv.sv
module sdac_frame_drv
  import sdac_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CODE_W = 12,
  parameter int T_CSS  = 3,
  parameter int T_HI   = 3,
  parameter int T_LO   = 4,
  parameter int T_CSH  = 2,
  parameter int T_LD1  = 2,
  parameter int T_LDW  = 3,
  parameter int T_LD2  = 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  output logic              done,
  output logic              dac_sck,
  output logic              dac_sdo,
  output logic              dac_cs_n,
  output logic              dac_ld_n
);

  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam int T_MAX   = imax(imax(imax(T_CSS, T_HI), imax(T_LO, T_CSH)),
                                imax(imax(T_LD1, T_LDW), T_LD2));
  localparam int CNT_W   = $clog2(T_MAX + 1);

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  seq_state_e       state_q, state_d;
  logic             tmr_load, expire, shift, last, frame_end, req_fire;
  logic [CNT_W-1:0] tmr_len;

  assign req_ready = rst_n && (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  sdac_seq_fsm #(
    .CNT_W(CNT_W), .T_CSS(T_CSS), .T_HI(T_HI), .T_LO(T_LO),
    .T_CSH(T_CSH), .T_LD1(T_LD1), .T_LDW(T_LDW), .T_LD2(T_LD2)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .expire   (expire),
    .last     (last),
    .state_q  (state_q),
    .state_d  (state_d),
    .tmr_load (tmr_load),
    .tmr_len  (tmr_len),
    .shift    (shift),
    .frame_end(frame_end)
  );

  sdac_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .expire(expire)
  );

  sdac_word_shifter #(.W(FRAME_W)) u_shf (
    .clk  (clk),
    .rst_n(rst_n),
    .load (req_fire),
    .word ({req_chan, req_code}),
    .shift(shift),
    .sdo  (dac_sdo),
    .last (last)
  );

  // pin registers follow the next state so they line up with state_q
  logic sck_d, cs_n_d, ld_n_d;
  always_comb begin
    sck_d  = (state_d == ST_HIGH);
    cs_n_d = !((state_d == ST_LEAD) || (state_d == ST_HIGH) ||
               (state_d == ST_LOW)  || (state_d == ST_TAIL));
    ld_n_d = (state_d != ST_LOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_sck  <= 1'b0;
      dac_cs_n <= 1'b1;
      dac_ld_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      dac_sck  <= sck_d;
      dac_cs_n <= cs_n_d;
      dac_ld_n <= ld_n_d;
      done     <= frame_end;
    end
  end

endmodule

// File: rtl/sdac_frame_drv_chk.sv
module sdac_frame_drv_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic dac_sck,
  input logic dac_sdo,
  input logic dac_cs_n,
  input logic dac_ld_n
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dac_sck && dac_cs_n && dac_ld_n));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_sck_in_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sck |-> !dac_cs_n);

  assert_load_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ld_n |-> (dac_cs_n && !dac_sck));

  assert_load_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ld_n) |-> $past(dac_cs_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  assert_sdo_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sck && $past(dac_sck)) |-> $stable(dac_sdo));

endmodule

bind sdac_frame_drv sdac_frame_drv_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .dac_sck  (dac_sck),
  .dac_sdo  (dac_sdo),
  .dac_cs_n (dac_cs_n),
  .dac_ld_n (dac_ld_n)
);

// File: tb/sdac_frame_drv_tb.sv
`timescale 1ns/1ps
module sdac_frame_drv_tb;

  localparam int T_CSS = 3, T_HI = 3, T_LO = 4, T_CSH = 2;
  localparam int T_LD1 = 2, T_LDW = 3, T_LD2 = 1;
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 12'h000}, {2'b01, 12'hFFF}, {2'b10, 12'h800},
    {2'b11, 12'h7FF}, {2'b01, 12'hA5C}, {2'b10, 12'h3C6}
  };

  logic clk = 1'b0;
  logic arst_n;
  logic req_valid, req_ready, done;
  logic [1:0] req_chan;
  logic [11:0] req_code;
  logic dac_sck, dac_sdo, dac_cs_n, dac_ld_n;

  always #5 clk = ~clk;

  sdac_frame_drv u_dut (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .done(done),
    .dac_sck(dac_sck), .dac_sdo(dac_sdo), .dac_cs_n(dac_cs_n), .dac_ld_n(dac_ld_n)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin monitor: run lengths of {cs_n, sck, ld_n}
  logic [2:0] pvec;
  int run, frames = 0, illegal = 0;
  logic [13:0] m_bits;
  int m_nbits, m_lead, m_tail, m_gap, m_ldw, m_hold, m_hi_bad, m_lo_bad, m_sdo_bad;
  int hold_cnt;
  bit in_hold = 0, m_done_rdy;

  always @(negedge clk) begin
    logic [2:0] vec;
    vec = {dac_cs_n, dac_sck, dac_ld_n};
    if (!arst_n) begin
      pvec = 3'b101;
      run  = 0;
    end else begin
      if (!dac_ld_n && (!dac_cs_n || dac_sck)) illegal++;
      if (vec == pvec) begin
        run++;
        if (vec == 3'b011 && dac_sdo != m_bits[0]) m_sdo_bad++;
      end else begin
        case (pvec)
          3'b001: begin
            if (m_nbits == 0) m_lead = run;
            else if (vec[2]) m_tail = run;
            else if (run != T_LO) m_lo_bad++;
          end
          3'b011: if (run != T_HI) m_hi_bad++;
          3'b101: if (!vec[0]) m_gap = run;
          3'b100: m_ldw = run;
          default: illegal++;
        endcase
        if (pvec == 3'b101 && vec == 3'b001) begin
          m_bits = '0; m_nbits = 0; m_lead = -1; m_tail = -1; m_gap = -1;
          m_ldw = -1; m_hold = -1; m_hi_bad = 0; m_lo_bad = 0; m_sdo_bad = 0;
        end
        if (vec == 3'b011) begin
          m_bits = {m_bits[12:0], dac_sdo};
          m_nbits++;
        end
        if (pvec == 3'b100) begin
          in_hold  = 1;
          hold_cnt = 0;
        end
        run = 1;
      end
      if (in_hold) begin
        if (done) begin
          m_hold     = hold_cnt;
          m_done_rdy = req_ready;
          in_hold    = 0;
          frames++;
        end else hold_cnt++;
      end
      pvec = vec;
    end
  end

  task automatic wait_frames(input int n);
    do begin
      @(negedge clk); #1;
    end while (frames < n);
  endtask

  task automatic check_frame(input logic [13:0] exp);
    chk(m_nbits == 14, "R5 bit count", m_nbits, 14);
    chk(m_bits == exp, "R3 frame bits", int'(m_bits), int'(exp));
    chk(m_lead == T_CSS, "R4 select lead", m_lead, T_CSS);
    chk(m_hi_bad == 0 && m_lo_bad == 0, "R5 clock phases", m_hi_bad + m_lo_bad, 0);
    chk(m_tail == T_CSH, "R6 select tail", m_tail, T_CSH);
    chk(m_gap == T_LD1, "R7 load setup", m_gap, T_LD1);
    chk(m_ldw == T_LDW, "R7 load width", m_ldw, T_LDW);
    chk(illegal == 0, "R7 load while selected", illegal, 0);
    chk(m_hold == T_LD2, "R8 load hold", m_hold, T_LD2);
    chk(m_done_rdy == 1'b1, "R8 ready with done", int'(m_done_rdy), 1);
    chk(m_sdo_bad == 0, "R9 data steady", m_sdo_bad, 0);
    @(negedge clk); #1;
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic send(input logic [13:0] w);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    {req_chan, req_code} = w;
    @(negedge clk); #1;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_code = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    // R1 reset and idle levels
    chk(!dac_sck && dac_cs_n && dac_ld_n, "R1 idle pins",
        int'({dac_cs_n, dac_sck, dac_ld_n}), 5);
    chk(req_ready == 1'b1, "R1 ready idle", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done idle", int'(done), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      wait_frames(frames + 1);
      check_frame(VEC[i]);
    end

    // R2: no valid, no frame
    repeat (20) @(negedge clk); #1;
    chk(frames == NV && dac_cs_n, "R2 no request idle", frames, NV);

    // R2: valid held through busy frame with changed data, then back to back
    @(negedge clk);
    req_valid = 1'b1;
    {req_chan, req_code} = {2'b11, 12'h123};
    @(negedge clk); #1;
    {req_chan, req_code} = {2'b00, 12'hEDC};
    wait_frames(NV + 1);
    check_frame({2'b11, 12'h123});
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 back to back accepted", int'(req_ready), 0);
    wait_frames(NV + 2);
    check_frame({2'b00, 12'hEDC});
    repeat (20) @(negedge clk); #1;
    chk(frames == NV + 2 && req_ready, "R2 no extra frame", frames, NV + 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule